// File: doc/BRIEF.md
# Refill Line Buffer Controller

This block keeps one cache line beside a set-associative cache controller. When a cacheable read misses in the tag and data arrays, it asks memory for the whole line. It collects the returning words in order. After the last word arrives, it keeps the line and answers later reads to that line by itself. This also covers the case where every way of the addressed set is locked: the buffer then acts as one more way and serves a line that the arrays do not hold.

The buffer is kept coherent with maintenance traffic. The following requests drop the held line so that a stale copy is never served:

- an invalidate aimed at the held line;
- a whole-cache invalidate;
- any uncached access;
- any cacheable write;
- a new miss.

A fill request always starts a fresh refill of its line, and that refill replaces the buffer contents. While a refill is running, the block holds off new requests.

Top module: `fbc_fill_buffer`

## Requirements
- R1: After reset the buffer is empty: `req_ready` is 1, `mem_req` is 0 and no read reports a hit.
- R2: An accepted cacheable read (`req_op` = 0, `req_write` = 0) that misses both the arrays (`arr_miss` = 1) and the buffer starts a refill. From the next cycle `mem_req` is 1 and `mem_line` equals the upper address bits, above the word offset, of that read.
- R3: Refill words are stored by offset in arrival order, starting at offset 0, one per cycle in which `mem_beat_valid` is 1. No hit is reported until the last word has been stored. After the last word, `req_ready` returns to 1.
- R4: After a refill, cacheable reads to the held line hit and return the word selected by the low address bits. Reads that hit in the arrays (`arr_miss` = 0) leave the buffer unchanged.
- R5: A hit invalidate (`req_op` = 1) whose line matches the held line empties the buffer. With any other line it has no effect.
- R6: A whole-cache invalidate (`req_op` = 2) empties the buffer whatever its address.
- R7: Any uncached access (`req_cacheable` = 0), read or write, empties the buffer.
- R8: Any cacheable write empties the buffer.
- R9: A fill request (`req_op` = 3) always starts a refill of its line, even when that line is already held. The new data replaces the old.
- R10: A read to the held line is served from the buffer even when the arrays miss, and it starts no refill.
- R11: While a refill runs, `req_ready` is 0 and every offered request is ignored.
- R12: A hit is reported only for cacheable reads with `req_op` = 0. Maintenance requests to the held line report no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle (low while a refill runs) |
| req_addr | input | ADDR_W | Word address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cacheable | input | 1 | 1 = cacheable access |
| req_op | input | 2 | 0 access, 1 hit invalidate, 2 whole-cache invalidate, 3 fill |
| arr_miss | input | 1 | The cache arrays miss on this request |
| mem_req | output | 1 | Refill in progress, memory words wanted |
| mem_line | output | ADDR_W-log2(BEATS) | Line address being refilled |
| mem_beat_valid | input | 1 | A refill word is present |
| mem_beat_data | input | DATA_W | Refill word |
| fb_hit | output | 1 | Buffer serves this read |
| fb_rdata | output | DATA_W | Word served, zero when there is no hit |

## Verification
The assertions assume that memory returns words only while `mem_req` is high and never more than one line's worth. They also assume that `arr_miss` is meaningful only for cacheable reads. The bench's memory model answers only while a refill is outstanding, with a stall on alternate cycles. It holds every request input steady from one falling edge to the next. It never offers a request on the cycle a refill completes. Stale-data cases bump a generation number held in the memory contents before each maintenance event, so any serving of old data shows up as a wrong word.

// File: rtl/fbc_pkg.sv
// Shared types for the refill line buffer.
// Assumes: requests carry a two-bit operation code with the values below.
package fbc_pkg;

    typedef enum logic [1:0] {
        FB_OP_ACCESS  = 2'd0,
        FB_OP_INV_HIT = 2'd1,
        FB_OP_INV_ALL = 2'd2,
        FB_OP_FILL    = 2'd3
    } fb_op_e;

    typedef enum logic {
        FB_ST_IDLE = 1'b0,
        FB_ST_FILL = 1'b1
    } fb_state_e;

    typedef struct packed {
        logic drop;   // empty the held line
        logic start;  // begin a refill of the request line
    } fb_evt_t;

endpackage

// File: rtl/fbc_classify.sv
// Classifies one request against the held line.
// Produces the hit flag and the drop/start events.
// Assumes: the inputs are stable for the cycle; events count only when accepted.
module fbc_classify
    import fbc_pkg::*;
#(
    parameter int TAG_W = 14
) (
    input  logic             accept,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic             req_write,
    input  logic             req_cacheable,
    input  logic             arr_miss,
    input  logic [TAG_W-1:0] req_line,
    input  logic             buf_valid,
    input  logic [TAG_W-1:0] buf_tag,
    output logic             hit,
    output fb_evt_t          evt
);

    logic lookup;
    logic match;
    logic is_acc;

    // Decode the lookup condition and the tag comparison.
    always_comb begin
        is_acc = (req_op == FB_OP_ACCESS);
        match  = (req_line == buf_tag);
        lookup = req_valid && is_acc && !req_write && req_cacheable;
        hit    = lookup && buf_valid && match;
    end

    // Derive the buffer events of an accepted request.
    always_comb begin
        evt.start = accept && ((req_op == FB_OP_FILL) ||
                               (lookup && !(buf_valid && match) && arr_miss));
        evt.drop  = accept && ((req_op == FB_OP_INV_ALL) ||
                               (req_op == FB_OP_INV_HIT && match) ||
                               (is_acc && (!req_cacheable || req_write)));
    end

endmodule

// File: rtl/fbc_fill_seq.sv
// Holds the line tag and valid bit, and runs the refill word counter.
// Assumes: words arrive in offset order; a start overrides a drop.
module fbc_fill_seq
    import fbc_pkg::*;
#(
    parameter int TAG_W = 14,
    parameter int BEATS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  fb_evt_t                  evt,
    input  logic [TAG_W-1:0]         start_line,
    input  logic                     beat_valid,
    output logic                     buf_valid,
    output logic [TAG_W-1:0]         buf_tag,
    output logic                     filling,
    output logic                     beat_we,
    output logic [$clog2(BEATS)-1:0] beat_idx
);

    localparam int CNT_W = $clog2(BEATS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    fb_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last_beat;

    // Flag the word that completes the line.
    always_comb begin
        filling   = (state_q == FB_ST_FILL);
        beat_we   = filling && beat_valid;
        beat_idx  = cnt_q;
        last_beat = beat_we && (cnt_q == LAST);
    end

    // Advance state, tag, valid bit and word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= FB_ST_IDLE;
            cnt_q     <= '0;
            buf_valid <= 1'b0;
            buf_tag   <= '0;
        end else if (filling) begin
            if (beat_we) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (last_beat) begin
                state_q   <= FB_ST_IDLE;
                buf_valid <= 1'b1;
            end
        end else if (evt.start) begin
            state_q   <= FB_ST_FILL;
            cnt_q     <= '0;
            buf_valid <= 1'b0;
            buf_tag   <= start_line;
        end else if (evt.drop) begin
            buf_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/fbc_line_store.sv
// Word storage for the single held line, with one register per offset.
// Assumes: one write per cycle at most; the read is asynchronous.
module fbc_line_store #(
    parameter int DATA_W = 32,
    parameter int BEATS  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(BEATS)-1:0] widx,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [$clog2(BEATS)-1:0] ridx,
    output logic [DATA_W-1:0]        rdata
);

    logic [DATA_W-1:0] word_q [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_word
        // Capture the refill word addressed to this offset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (we && (widx == g)) begin
                word_q[g] <= wdata;
            end
        end
    end

    // Select the requested word.
    always_comb begin
        rdata = word_q[ridx];
    end

endmodule

// File: rtl/fbc_fill_buffer.sv
// Top of the refill line buffer.
// Joins the request classifier, the refill sequencer and the line store.
// Assumes: BEATS is a power of two, at least 2; addresses are word addresses.
module fbc_fill_buffer
    import fbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int BEATS  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    output logic                                 req_ready,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic                                 req_write,
    input  logic                                 req_cacheable,
    input  logic [1:0]                           req_op,
    input  logic                                 arr_miss,
    output logic                                 mem_req,
    output logic [ADDR_W-$clog2(BEATS)-1:0]      mem_line,
    input  logic                                 mem_beat_valid,
    input  logic [DATA_W-1:0]                    mem_beat_data,
    output logic                                 fb_hit,
    output logic [DATA_W-1:0]                    fb_rdata
);

    localparam int OFFS_W = $clog2(BEATS);
    localparam int TAG_W  = ADDR_W - OFFS_W;

    logic [TAG_W-1:0]  req_line;
    logic [OFFS_W-1:0] req_offs;
    logic              accept;
    logic              hit;
    fb_evt_t           evt;
    logic              buf_valid;
    logic [TAG_W-1:0]  buf_tag;
    logic              filling;
    logic              beat_we;
    logic [OFFS_W-1:0] beat_idx;
    logic [DATA_W-1:0] word;

    // Split the address and form the accept strobe.
    always_comb begin
        req_line  = req_addr[ADDR_W-1:OFFS_W];
        req_offs  = req_addr[OFFS_W-1:0];
        req_ready = !filling;
        accept    = req_valid && req_ready;
    end

    fbc_classify #(.TAG_W(TAG_W)) u_cls (
        .accept        (accept),
        .req_valid     (req_valid),
        .req_op        (req_op),
        .req_write     (req_write),
        .req_cacheable (req_cacheable),
        .arr_miss      (arr_miss),
        .req_line      (req_line),
        .buf_valid     (buf_valid),
        .buf_tag       (buf_tag),
        .hit           (hit),
        .evt           (evt)
    );

    fbc_fill_seq #(.TAG_W(TAG_W), .BEATS(BEATS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt        (evt),
        .start_line (req_line),
        .beat_valid (mem_beat_valid),
        .buf_valid  (buf_valid),
        .buf_tag    (buf_tag),
        .filling    (filling),
        .beat_we    (beat_we),
        .beat_idx   (beat_idx)
    );

    fbc_line_store #(.DATA_W(DATA_W), .BEATS(BEATS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (beat_we),
        .widx  (beat_idx),
        .wdata (mem_beat_data),
        .ridx  (req_offs),
        .rdata (word)
    );

    // Drive the memory side and the hit data.
    always_comb begin
        mem_req  = filling;
        mem_line = buf_tag;
        fb_hit   = hit;
        fb_rdata = hit ? word : '0;
    end

endmodule

// File: rtl/fbc_fill_buffer_chk.sv
// Checker for the refill line buffer, bound to the top module.
// Assumes: request inputs are stable across each clock edge.
module fbc_fill_buffer_chk #(
    parameter int TAG_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [TAG_W-1:0] req_line,
    input logic             req_write,
    input logic             req_cacheable,
    input logic [1:0]       req_op,
    input logic             arr_miss,
    input logic             mem_req,
    input logic [TAG_W-1:0] mem_line,
    input logic             fb_hit,
    input logic             buf_valid,
    input logic [TAG_W-1:0] buf_tag
);

    logic acc;
    logic rd_c;
    assign acc  = req_valid && req_ready;
    assign rd_c = (req_op == 2'd0) && !req_write && req_cacheable;

    p_miss_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rd_c && arr_miss && !fb_hit) |=> (mem_req && mem_line == $past(req_line)));

    p_no_hit_filling_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !fb_hit);

    p_array_hit_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && rd_c && !arr_miss) |=> (buf_valid == $past(buf_valid) && buf_tag == $past(buf_tag)));

    p_inv_hit_kills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd1 && req_line == buf_tag) |=> !buf_valid);

    p_inv_all_kills_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd2) |=> !buf_valid);

    p_uncached_kills_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd0 && !req_cacheable) |=> !buf_valid);

    p_write_kills_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd0 && req_cacheable && req_write) |=> !buf_valid);

    p_fill_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_op == 2'd3) |=> (mem_req && mem_line == $past(req_line)));

    p_extra_way_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fb_hit && req_ready) |=> (!mem_req && buf_valid));

    p_busy_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    p_hit_reads_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fb_hit |-> (req_valid && rd_c && buf_valid));

endmodule

bind fbc_fill_buffer fbc_fill_buffer_chk #(.TAG_W(TAG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_line      (req_line),
    .req_write     (req_write),
    .req_cacheable (req_cacheable),
    .req_op        (req_op),
    .arr_miss      (arr_miss),
    .mem_req       (mem_req),
    .mem_line      (mem_line),
    .fb_hit        (fb_hit),
    .buf_valid     (buf_valid),
    .buf_tag       (buf_tag)
);

// File: tb/fbc_fill_buffer_test.sv
`timescale 1ns/1ps
module fbc_fill_buffer_test;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;
    localparam int BEATS  = 4;
    localparam int OFFS_W = $clog2(BEATS);
    localparam int TAG_W  = ADDR_W - OFFS_W;
    localparam int NLINES = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_write = 1'b0;
    logic              req_cacheable = 1'b1;
    logic [1:0]        req_op = 2'd0;
    logic              arr_miss = 1'b1;
    logic              mem_req;
    logic [TAG_W-1:0]  mem_line;
    logic              mem_beat_valid = 1'b0;
    logic [DATA_W-1:0] mem_beat_data = '0;
    logic              fb_hit;
    logic [DATA_W-1:0] fb_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int gen = 0;
    bit finished = 1'b0;

    // Bench model of the held line.
    bit               m_valid = 1'b0;
    logic [TAG_W-1:0] m_tag = '0;
    int               m_gen = 0;

    // Memory model state.
    int tb_beat = 0;
    bit stall = 1'b0;

    always #5 clk = ~clk;

    fbc_fill_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_cacheable(req_cacheable),
        .req_op(req_op), .arr_miss(arr_miss), .mem_req(mem_req), .mem_line(mem_line),
        .mem_beat_valid(mem_beat_valid), .mem_beat_data(mem_beat_data),
        .fb_hit(fb_hit), .fb_rdata(fb_rdata)
    );

    function automatic logic [DATA_W-1:0] mem_word(int line, int w, int g);
        return DATA_W'(g) * 32'h0100_0000 + DATA_W'(line) * 32'h100 + DATA_W'(w);
    endfunction

    function automatic int line_of(int i);
        return (i * 37 + 5) % (1 << TAG_W);
    endfunction

    // Memory responder: one word per non-stalled cycle while a refill is wanted.
    always @(negedge clk) begin
        if (mem_req) begin
            stall <= !stall;
            if (!stall && tb_beat < BEATS) begin
                mem_beat_valid <= 1'b1;
                mem_beat_data  <= mem_word(int'(mem_line), tb_beat, gen);
                tb_beat        <= tb_beat + 1;
            end else begin
                mem_beat_valid <= 1'b0;
            end
        end else begin
            mem_beat_valid <= 1'b0;
            tb_beat        <= 0;
            stall          <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One request with model prediction; poke >= 0 offers that op during the refill.
    task automatic access(input string tag, input logic [1:0] op, input bit wr,
                          input bit cach, input int addr, input bit amiss, input int poke);
        logic [TAG_W-1:0]  line;
        int                offs;
        bit                lookup;
        bit                exp_hit;
        bit                exp_start;
        bit                exp_drop;
        int                waited;
        line = TAG_W'(addr >> OFFS_W);
        offs = addr % BEATS;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_write = wr; req_cacheable = cach;
        req_addr = ADDR_W'(addr); arr_miss = amiss;
        #1;
        lookup    = (op == 2'd0) && !wr && cach;
        exp_hit   = lookup && m_valid && (m_tag == line);
        exp_start = (op == 2'd3) || (lookup && !exp_hit && amiss);
        exp_drop  = (op == 2'd2) || (op == 2'd1 && m_tag == line) ||
                    (op == 2'd0 && (!cach || wr));
        chk(req_ready == 1'b1, tag, "ready before request", 32'(req_ready), 32'd1);
        chk(fb_hit == exp_hit, tag, "hit flag", 32'(fb_hit), 32'(exp_hit));
        if (exp_hit)
            chk(fb_rdata == mem_word(int'(line), offs, m_gen), tag, "hit data",
                fb_rdata, mem_word(int'(line), offs, m_gen));
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_start) begin
            chk(mem_req && mem_line == line, tag, "refill line", 32'(mem_line), 32'(line));
            m_valid = 1'b0;
            if (poke >= 0) begin
                req_valid = 1'b1; req_op = 2'(poke); req_write = 1'b0;
                req_cacheable = 1'b1; arr_miss = 1'b1;
            end
            waited = 0;
            while (!req_ready && waited < 4 * BEATS + 8) begin
                #1;
                if (poke >= 0)
                    chk(fb_hit == 1'b0, "R3", "no hit while filling", 32'(fb_hit), 32'd0);
                @(negedge clk);
                waited++;
            end
            req_valid = 1'b0;
            chk(req_ready == 1'b1, "R3", "refill completes", 32'(req_ready), 32'd1);
            m_valid = 1'b1; m_tag = line; m_gen = gen;
        end else if (exp_drop) begin
            m_valid = 1'b0;
        end
    endtask

    // Watchdog.
    initial begin
        #1_000_000;
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int ln;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);
        chk(mem_req == 1'b0, "R1", "no refill after reset", 32'(mem_req), 32'd0);
        access("R1", 2'd0, 1'b0, 1'b1, 12, 1'b0, -1);   // array hit, buffer empty: no hit

        for (int i = 0; i < NLINES; i++) begin
            ln = line_of(i);
            access("R2", 2'd0, 1'b0, 1'b1, ln * BEATS + 1, 1'b1, -1);
            for (int w = 0; w < BEATS; w++)
                access("R10", 2'd0, 1'b0, 1'b1, ln * BEATS + w, 1'b1, -1);
            access("R4", 2'd0, 1'b0, 1'b1, line_of(i + 9) * BEATS, 1'b0, -1);
            access("R4", 2'd0, 1'b0, 1'b1, ln * BEATS + 2, 1'b0, -1);
            access("R12", 2'd2 - 2'd1, 1'b0, 1'b1, line_of(i + 3) * BEATS, 1'b1, -1);
            gen++;
            case (i)
                0: access("R5", 2'd1, 1'b0, 1'b1, ln * BEATS + 3, 1'b1, -1);
                1: access("R6", 2'd2, 1'b0, 1'b1, line_of(20) * BEATS, 1'b1, -1);
                2: access("R7", 2'd0, 1'b0, 1'b0, ln * BEATS + 1, 1'b1, -1);
                3: access("R7", 2'd0, 1'b1, 1'b0, line_of(21) * BEATS, 1'b1, -1);
                4: access("R8", 2'd0, 1'b1, 1'b1, ln * BEATS, 1'b1, -1);
                default: access("R9", 2'd3, 1'b0, 1'b1, ln * BEATS, 1'b1, -1);
            endcase
            for (int w = 0; w < BEATS; w++)
                access("R5", 2'd0, 1'b0, 1'b1, ln * BEATS + w, 1'b1, -1);
        end

        // Busy window: offered requests are ignored and no hit shows.
        gen++;
        ln = line_of(30);
        access("R11", 2'd0, 1'b0, 1'b1, ln * BEATS, 1'b1, 0);
        access("R11", 2'd0, 1'b0, 1'b1, ln * BEATS + 3, 1'b1, -1);
        ln = line_of(31);
        access("R11", 2'd3, 1'b0, 1'b1, ln * BEATS, 1'b1, 2);
        for (int w = 0; w < BEATS; w++)
            access("R11", 2'd0, 1'b0, 1'b1, ln * BEATS + w, 1'b1, -1);
        access("R12", 2'd1, 1'b0, 1'b1, ln * BEATS + 1, 1'b1, -1);
        access("R12", 2'd0, 1'b0, 1'b1, ln * BEATS + 1, 1'b1, -1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule